// File: doc/BRIEF.md
# ADC Scan Sequencer with Multiplexer Control

This block schedules the conversions of a successive-approximation ADC. After a start trigger it closes the sampling switch for a programmable time, then runs one approximation strobe per result bit, from the most significant bit down. It assembles the result from a comparator input and pulses end-of-conversion with the final code. It walks a programmed list of 5-bit channel numbers and drives the analog input multiplexer select. Four run modes are offered: a single conversion, one pass over the list, repeated passes until a stop request, and a repeated mode in which the multiplexer is never parked.

The multiplexer is moved to the next channel partway through each conversion, not after it. When a run ends it is parked on the internal channel 31, except in the never-park mode. A move to the channel already selected is suppressed. Every real move is reported with the number of select bits that changed, so that software can rank channel orderings by switching noise; a Gray-ordered list costs one bit per move.

The channel list, its length, the mode and the sampling time are assumed stable from the trigger until the run ends. The resolution must be at least 7 bits.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the select output is 31 (5'b11111), and the sampling enable, strobe, end-of-conversion, end-of-sequence, switch-valid and overrun outputs are all low.
- R2: A trigger accepted while idle raises the sampling enable in the next clock. It stays high for ceil(S/2) clocks, where S is the sampling time in half-clock units (5 means 2.5 clocks, 1281 means 640.5). The strobe is then high for exactly RES clocks, and the two are never high together.
- R3: During the strobe clock of bit b (RES-1 first), the trial word holds the bits already decided, with bit b set and every lower bit clear. The comparator input sampled in that clock becomes bit b of the result; 1 keeps the bit. At S=5 and RES=12, eoc is high in the 16th clock after the trigger clock, 15 clocks after sampling starts, with the completed code on the data output.
- R4: In scan mode the select changes to the next list entry at the clock edge that decides bit RES-6. That clock edge falls within the current conversion.
- R5: Mode 0 (single) converts list entry 0 only, whatever the length input says. Mode 1 (scan) converts entries 0 to L-1, where L is the length field plus one. In both modes the select moves to 31 at the bit RES-6 edge of the last conversion.
- R6: When the scheduled channel equals the one already selected, the select output does not change and no switch-valid pulse is issued.
- R7: Mode 2 (continuous) repeats the list with no idle clock between conversions. A stop request makes the pass in progress the last one, provided the request comes before the bit RES-6 edge of that pass's last entry. The select goes to 31 only after the last conversion of that final pass.
- R8: Mode 3 (bulb) repeats like mode 2, but the select is never moved to 31; after the final conversion it stays on the last converted channel.
- R9: Each clock in which the select differs from the clock before carries a one-clock switch-valid pulse. The distance output in that clock equals the number of differing bits between the old and new select values.
- R10: A trigger that arrives while a run is in progress is ignored. It gives a one-clock overrun pulse in the following clock and no change in timing or results.
- R11: End-of-sequence is high together with the eoc of the last list entry of each pass; in single mode it comes with every eoc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADC clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trig | input | 1 | Start trigger, sampled each clock |
| stop_req | input | 1 | Ends repeated modes after the current pass |
| mode | input | 2 | 0 single, 1 scan, 2 continuous, 3 bulb |
| ch_list | input | N_ENT*5 | Channel list, entry k in bits 5k+4:5k |
| seq_last | input | clog2(N_ENT) | Index of the last list entry (length minus one) |
| smp_half | input | SMP_W | Sampling time in half-clock units |
| cmp_in | input | 1 | Comparator result for the bit under trial |
| mux_sel | output | 5 | Input multiplexer select |
| smp_en | output | 1 | Sampling switch closed |
| sar_strobe | output | 1 | One approximation step per clock |
| sar_trial | output | RES | Trial word for the comparator DAC |
| eoc | output | 1 | End-of-conversion pulse |
| eos | output | 1 | End-of-sequence pulse |
| conv_data | output | RES | Result, valid with eoc |
| overrun | output | 1 | Trigger arrived during a run |
| sw_valid | output | 1 | The select has just changed |
| sw_dist | output | 3 | Bits changed in that move |

## Verification
The hardest situation to reach is the end of a repeated run. Whether the select parks, holds, or wraps to entry 0 depends on when the stop request arrives relative to the decision edge of the last entry. The bench raises the stop request in the first clock of the final pass, after the previous pass has already committed to wrapping. It then follows the select clock by clock through the wrap, the final middle-of-conversion edge and the idle clocks that follow. It also checks that a bulb run ends on the held channel and that the next scan run starts from that channel.

// File: rtl/adc_seq_pkg.sv
// Shared constants, mode and state types for the ADC scan sequencer.
package adc_seq_pkg;

    localparam int SEQ_CH_W   = 5;
    localparam int SEQ_DIST_W = $clog2(SEQ_CH_W + 1);
    localparam logic [SEQ_CH_W-1:0] SEQ_PARK_CH = '1;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'd0,
        MODE_SCAN   = 2'd1,
        MODE_CONT   = 2'd2,
        MODE_BULB   = 2'd3
    } seq_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SAMP = 2'd1,
        ST_CONV = 2'd2
    } seq_state_e;

endpackage

// File: rtl/adc_sar_steps.sv
// Successive-approximation bit register.
// Produces the trial word for the bit under test and records the comparator
// decision on each step. Assumes bit_idx < RES whenever step is high.
module adc_sar_steps #(
    parameter int RES   = 12,
    parameter int BIT_W = $clog2(RES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [BIT_W-1:0] bit_idx,
    input  logic             cmp_in,
    output logic [RES-1:0]   trial,
    output logic [RES-1:0]   code_next
);

    logic [RES-1:0] acc;
    logic [RES-1:0] onehot;

    // Purpose: trial word and the result after the current decision.
    always_comb begin
        onehot            = '0;
        onehot[bit_idx]   = 1'b1;
        code_next         = acc;
        code_next[bit_idx] = cmp_in;
        trial             = step ? (acc | onehot) : '0;
    end

    // Purpose: hold decided bits, cleared while sampling.
    always_ff @(posedge clk) begin
        if (!rst_n)      acc <= '0;
        else if (clear)  acc <= '0;
        else if (step)   acc <= code_next;
    end

endmodule

// File: rtl/adc_mux_ctrl.sv
// Multiplexer select register with switch suppression and cost report.
// A load to the value already held changes nothing; a real change pulses
// sw_valid for one clock with the count of changed select bits.
module adc_mux_ctrl
    import adc_seq_pkg::*;
#(
    parameter int CH_W   = SEQ_CH_W,
    parameter int DIST_W = SEQ_DIST_W,
    parameter logic [CH_W-1:0] PARK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CH_W-1:0]   nxt_ch,
    output logic [CH_W-1:0]   mux_sel,
    output logic              sw_valid,
    output logic [DIST_W-1:0] sw_dist
);

    logic [DIST_W-1:0] diff_cnt;

    // Purpose: count differing bits between held and requested channel.
    always_comb begin
        diff_cnt = '0;
        for (int i = 0; i < CH_W; i++) begin
            diff_cnt = diff_cnt + DIST_W'(mux_sel[i] ^ nxt_ch[i]);
        end
    end

    // Purpose: update the select only on a real change and report it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mux_sel  <= PARK;
            sw_valid <= 1'b0;
            sw_dist  <= '0;
        end else begin
            sw_valid <= 1'b0;
            if (load && (nxt_ch != mux_sel)) begin
                mux_sel  <= nxt_ch;
                sw_valid <= 1'b1;
                sw_dist  <= diff_cnt;
            end
        end
    end

endmodule

// File: rtl/adc_scan_seq.sv
// ADC scan sequencer top.
// Runs sampling then RES approximation steps per conversion, walks the
// channel list according to the mode, and moves the multiplexer at the edge
// deciding bit RES-6. Assumes RES >= 7 and configuration stable during a run.
module adc_scan_seq
    import adc_seq_pkg::*;
#(
    parameter int RES   = 12,
    parameter int N_ENT = 4,
    parameter int SMP_W = 11,
    localparam int CH_W   = SEQ_CH_W,
    localparam int DIST_W = SEQ_DIST_W,
    localparam int IDX_W  = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    trig,
    input  logic                    stop_req,
    input  logic [1:0]              mode,
    input  logic [N_ENT*CH_W-1:0]   ch_list,
    input  logic [IDX_W-1:0]        seq_last,
    input  logic [SMP_W-1:0]        smp_half,
    input  logic                    cmp_in,
    output logic [CH_W-1:0]         mux_sel,
    output logic                    smp_en,
    output logic                    sar_strobe,
    output logic [RES-1:0]          sar_trial,
    output logic                    eoc,
    output logic                    eos,
    output logic [RES-1:0]          conv_data,
    output logic                    overrun,
    output logic                    sw_valid,
    output logic [DIST_W-1:0]       sw_dist
);

    localparam int BIT_W   = $clog2(RES);
    localparam int MID_BIT = RES - 6;

    seq_state_e       state;
    seq_mode_e        md;
    logic [SMP_W-1:0] cnt;
    logic [BIT_W-1:0] bit_idx;
    logic [IDX_W-1:0] idx;
    logic             final_q;
    logic             stop_pend;

    logic [CH_W-1:0]  ent [N_ENT];
    logic [SMP_W:0]   half_up;
    logic [SMP_W-1:0] nsamp;
    logic [SMP_W-1:0] nsamp_m1;
    logic [IDX_W-1:0] eff_last;
    logic [IDX_W-1:0] idx_nx;
    logic             at_last;
    logic             is_final;
    logic             mid_edge;
    logic             mux_load;
    logic [CH_W-1:0]  next_ch;
    logic [CH_W-1:0]  mux_nxt;
    logic [RES-1:0]   code_next;

    assign md = seq_mode_e'(mode);

    // Unpack the flat channel list into entries.
    for (genvar g = 0; g < N_ENT; g++) begin : g_unpack
        assign ent[g] = ch_list[g*CH_W +: CH_W];
    end

    // Purpose: sampling length in clocks, rounded up from half clocks.
    always_comb begin
        half_up  = {1'b0, smp_half} + (SMP_W+1)'(1);
        nsamp    = half_up[SMP_W:1];
        nsamp_m1 = (nsamp == '0) ? '0 : nsamp - 1'b1;
    end

    // Purpose: list position, end-of-run decision and next channel.
    always_comb begin
        eff_last = (md == MODE_SINGLE) ? '0 : seq_last;
        at_last  = (idx == eff_last);
        idx_nx   = at_last ? '0 : idx + 1'b1;
        is_final = at_last && ((md == MODE_SINGLE) || (md == MODE_SCAN) ||
                               stop_pend || stop_req);
        if (!is_final)              next_ch = ent[idx_nx];
        else if (md == MODE_BULB)   next_ch = mux_sel;
        else                        next_ch = SEQ_PARK_CH;
        mid_edge = (state == ST_CONV) && (bit_idx == BIT_W'(MID_BIT));
        mux_load = ((state == ST_IDLE) && trig) || mid_edge;
        mux_nxt  = (state == ST_IDLE) ? ent[0] : next_ch;
    end

    // Purpose: phase outputs decoded from the state.
    assign smp_en     = (state == ST_SAMP);
    assign sar_strobe = (state == ST_CONV);

    // Purpose: sequencing state machine and result/flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            bit_idx   <= '0;
            idx       <= '0;
            final_q   <= 1'b0;
            eoc       <= 1'b0;
            eos       <= 1'b0;
            conv_data <= '0;
            overrun   <= 1'b0;
        end else begin
            eoc     <= 1'b0;
            eos     <= 1'b0;
            overrun <= trig && (state != ST_IDLE);
            case (state)
                ST_IDLE: begin
                    if (trig) begin
                        state   <= ST_SAMP;
                        cnt     <= nsamp_m1;
                        idx     <= '0;
                        final_q <= 1'b0;
                    end
                end
                ST_SAMP: begin
                    if (cnt == '0) begin
                        state   <= ST_CONV;
                        bit_idx <= BIT_W'(RES-1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_CONV: begin
                    if (mid_edge) final_q <= is_final;
                    if (bit_idx == '0) begin
                        eoc       <= 1'b1;
                        eos       <= at_last;
                        conv_data <= code_next;
                        idx       <= idx_nx;
                        if (final_q) begin
                            state <= ST_IDLE;
                        end else begin
                            state <= ST_SAMP;
                            cnt   <= nsamp_m1;
                        end
                    end else begin
                        bit_idx <= bit_idx - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Purpose: remember a stop request until the run ends.
    always_ff @(posedge clk) begin
        if (!rst_n)                 stop_pend <= 1'b0;
        else if (state == ST_IDLE)  stop_pend <= 1'b0;
        else if (stop_req)          stop_pend <= 1'b1;
    end

    adc_sar_steps #(.RES(RES), .BIT_W(BIT_W)) u_sar (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (smp_en),
        .step      (sar_strobe),
        .bit_idx   (bit_idx),
        .cmp_in    (cmp_in),
        .trial     (sar_trial),
        .code_next (code_next)
    );

    adc_mux_ctrl #(.CH_W(CH_W), .DIST_W(DIST_W), .PARK(SEQ_PARK_CH)) u_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (mux_load),
        .nxt_ch   (mux_nxt),
        .mux_sel  (mux_sel),
        .sw_valid (sw_valid),
        .sw_dist  (sw_dist)
    );

endmodule

// File: rtl/adc_scan_seq_chk.sv
// Port-level temporal checks for adc_scan_seq, attached by bind.
module adc_scan_seq_chk
    import adc_seq_pkg::*;
#(
    parameter int CH_W   = SEQ_CH_W,
    parameter int DIST_W = SEQ_DIST_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trig,
    input logic              smp_en,
    input logic              sar_strobe,
    input logic [CH_W-1:0]   mux_sel,
    input logic              sw_valid,
    input logic [DIST_W-1:0] sw_dist,
    input logic              eoc,
    input logic              eos,
    input logic              overrun
);

    // R2: conversion steps always follow a sampling phase
    a_r2_samp_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sar_strobe) |-> $past(smp_en));

    // R3: a result appears only right after an approximation step
    a_r3_eoc_after_step: assert property (@(posedge clk) disable iff (!rst_n)
        eoc |-> $past(sar_strobe));

    // R6: without a reported switch the select holds
    a_r6_hold_select: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_valid |-> $stable(mux_sel));

    // R9: a reported switch is a real change with nonzero cost
    a_r9_real_switch: assert property (@(posedge clk) disable iff (!rst_n)
        sw_valid |-> ((sw_dist != '0) && (mux_sel != $past(mux_sel))));

    // R4: moves happen only at run start or during approximation
    a_r4_switch_timing: assert property (@(posedge clk) disable iff (!rst_n)
        sw_valid |-> ($past(sar_strobe) || smp_en));

    // R10: overrun only follows a trigger during a run
    a_r10_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> ($past(trig) && ($past(smp_en) || $past(sar_strobe))));

    // R11: end of sequence coincides with end of conversion
    a_r11_eos_with_eoc: assert property (@(posedge clk) disable iff (!rst_n)
        eos |-> eoc);

endmodule

bind adc_scan_seq adc_scan_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig       (trig),
    .smp_en     (smp_en),
    .sar_strobe (sar_strobe),
    .mux_sel    (mux_sel),
    .sw_valid   (sw_valid),
    .sw_dist    (sw_dist),
    .eoc        (eoc),
    .eos        (eos),
    .overrun    (overrun)
);

// File: tb/adc_scan_seq_bench.sv
`timescale 1ns/1ps
module adc_scan_seq_bench;

    localparam int RES   = 12;
    localparam int N_ENT = 4;
    localparam int SMP_W = 11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              trig = 1'b0;
    logic              stop_req = 1'b0;
    logic [1:0]        mode = 2'd0;
    logic [N_ENT*5-1:0] ch_list = '0;
    logic [1:0]        seq_last = '0;
    logic [SMP_W-1:0]  smp_half = 11'd5;
    logic              cmp_in = 1'b0;
    logic [4:0]        mux_sel;
    logic              smp_en, sar_strobe, eoc, eos, overrun, sw_valid;
    logic [RES-1:0]    sar_trial, conv_data;
    logic [2:0]        sw_dist;

    int vectors = 0;
    int fails   = 0;
    int cyc     = 0;
    int prev_mux = 31;

    always #2 clk = ~clk;

    adc_scan_seq #(.RES(RES), .N_ENT(N_ENT), .SMP_W(SMP_W)) u_adc_scan_seq (
        .clk(clk), .rst_n(rst_n), .trig(trig), .stop_req(stop_req),
        .mode(mode), .ch_list(ch_list), .seq_last(seq_last),
        .smp_half(smp_half), .cmp_in(cmp_in), .mux_sel(mux_sel),
        .smp_en(smp_en), .sar_strobe(sar_strobe), .sar_trial(sar_trial),
        .eoc(eoc), .eos(eos), .conv_data(conv_data), .overrun(overrun),
        .sw_valid(sw_valid), .sw_dist(sw_dist)
    );

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung act=%0d exp<150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int popc(input int a, input int b);
        int n = 0;
        for (int i = 0; i < 5; i++) n += ((a >> i) & 1) ^ ((b >> i) & 1);
        return n;
    endfunction

    function automatic int patf(input int seed, input int j);
        return (seed * 2731 + j * 1657 + 173) & 12'hFFF;
    endfunction

    // One run: md 0 single, 1 scan, 2 continuous, 3 bulb.
    task automatic run(input int md, input int len, input int sh,
                       input int seed, input int passes, input bit ovr,
                       input int c0, input int c1, input int c2, input int c3);
        int lst[4];
        int ns, per, effl, nconv;
        string mtag;
        lst[0] = c0; lst[1] = c1; lst[2] = c2; lst[3] = c3;
        ns    = (sh + 1) / 2;
        per   = ns + RES;
        effl  = (md == 0) ? 1 : len;
        nconv = (md == 0) ? 1 : ((md == 1) ? len : passes * len);
        mtag  = (md == 0) ? "R5" : (md == 1) ? "R4" : (md == 2) ? "R7" : "R8";
        @(negedge clk);
        mode     = 2'(md);
        seq_last = 2'(len - 1);
        smp_half = SMP_W'(sh);
        for (int i = 0; i < 4; i++) ch_list[i*5 +: 5] = 5'(lst[i]);
        trig   = 1'b1;
        cmp_in = 1'b0;
        for (int c = 1; c <= nconv * per + 2; c++) begin
            int j, ph, bitn, jj, cur, nx, emux, etrial, pv;
            bit act, esmp, estb, eeoc, eeos;
            @(negedge clk);
            j    = (c - 1) / per;
            ph   = (c - 1) % per + 1;
            act  = (j < nconv);
            esmp = act && (ph <= ns);
            estb = act && (ph > ns);
            bitn = RES - 1 - (ph - ns - 1);
            pv   = patf(seed, j);
            etrial = estb ? (((pv >> (bitn + 1)) << (bitn + 1)) | (1 << bitn)) : 0;
            eeoc = (ph == 1) && (j >= 1) && (j <= nconv);
            eeos = eeoc && (((j - 1) % effl) == effl - 1);
            jj   = act ? j : nconv - 1;
            cur  = lst[jj % effl];
            nx   = (jj < nconv - 1) ? lst[(jj + 1) % effl] : ((md == 3) ? cur : 31);
            emux = (act && (ph <= ns + 6)) ? cur : nx;
            chk(smp_en == esmp, "R2", "smp_en", int'(smp_en), int'(esmp));
            chk(sar_strobe == estb, "R2", "strobe", int'(sar_strobe), int'(estb));
            chk(int'(sar_trial) == etrial, "R3", "trial", int'(sar_trial), etrial);
            chk(eoc == eeoc, "R3", "eoc", int'(eoc), int'(eeoc));
            if (eeoc)
                chk(int'(conv_data) == patf(seed, j - 1), "R3", "data",
                    int'(conv_data), patf(seed, j - 1));
            chk(eos == eeos, "R11", "eos", int'(eos), int'(eeos));
            chk(int'(mux_sel) == emux, mtag, "mux_sel", int'(mux_sel), emux);
            // R6: a suppressed move gives no pulse; R9: real moves report cost
            chk(sw_valid == (emux != prev_mux), "R9", "sw_valid",
                int'(sw_valid), int'(emux != prev_mux));
            if (emux != prev_mux)
                chk(int'(sw_dist) == popc(emux, prev_mux), "R9", "sw_dist",
                    int'(sw_dist), popc(emux, prev_mux));
            chk(overrun == (ovr && c == 4), "R10", "overrun",
                int'(overrun), int'(ovr && c == 4));
            prev_mux = emux;
            trig     = ovr && (c == 3);
            stop_req = (md >= 2) && (c == (nconv - len) * per + 1);
            cmp_in   = estb ? ((pv >> bitn) & 1) : (c & 1);
        end
        trig     = 1'b0;
        stop_req = 1'b0;
    endtask

    initial begin
        int sv[3];
        int cv[4];
        sv[0] = 5; sv[1] = 6; sv[2] = 9;
        cv[0] = 0; cv[1] = 5; cv[2] = 15; cv[3] = 31;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(mux_sel == 5'd31, "R1", "mux_sel", int'(mux_sel), 31);
        chk(!smp_en && !sar_strobe, "R1", "phase", int'({smp_en, sar_strobe}), 0);
        chk(!eoc && !eos && !sw_valid && !overrun, "R1", "flags",
            int'({eoc, eos, sw_valid, overrun}), 0);
        // R5: single conversions over channels and sampling times
        for (int s = 0; s < 3; s++)
            for (int k = 0; k < 4; k++)
                run(0, 4, sv[s], s * 4 + k, 1, (k == 1), cv[k], 9, 9, 9);
        // R4 R5: scan over every length, Gray and non-Gray lists
        for (int l = 1; l <= 4; l++) begin
            run(1, l, 5, 20 + l, 1, 1'b0, 0, 1, 3, 2);
            run(1, l, 7, 30 + l, 1, 1'b0, 6, 15, 6, 15);
        end
        // R6: same channel throughout, no switch inside the run
        run(1, 4, 5, 41, 1, 1'b0, 9, 9, 9, 9);
        // R2: longest sampling time
        run(1, 3, 1281, 42, 1, 1'b0, 17, 16, 18, 0);
        // R7: continuous on one channel and on a list, with overrun
        run(2, 1, 5, 50, 3, 1'b0, 12, 0, 0, 0);
        run(2, 3, 6, 51, 2, 1'b1, 4, 5, 7, 0);
        // R8: bulb never parks, then a scan starts from the held channel
        run(3, 1, 5, 60, 3, 1'b0, 20, 0, 0, 0);
        run(3, 2, 5, 61, 2, 1'b1, 21, 22, 0, 0);
        run(1, 2, 5, 62, 1, 1'b0, 22, 23, 0, 0);
        repeat (4) @(negedge clk);
        summary();
        $finish;
    end

endmodule